// File: doc/BRIEF.md
# Interrupt Status and Mask Register Pair

This block keeps a 32-bit word of sticky event flags and a 32-bit enable word, both reached through a small single-cycle register port. Single-cycle pulses from the block's event sources set flags. A flag stays set until software writes a one to its position in the status word. Writing a zero to a position leaves that flag alone.

Three fixed groups of flag positions are summarised on their own pins: transmit activity, receive activity and fatal error. Each summary pin looks only at flags that are enabled in the enable word. A level interrupt output is high when any enabled flag is set, and it lags the register state by one clock. Flag position 2 means that the transmitter has halted because it found a descriptor owned by the host. That flag also has a pin of its own, which shows the raw flag whatever the enable word holds.

The register port has two registers. `csr_sel` = 0 selects the status word and `csr_sel` = 1 selects the enable word. Reads are combinational and have no side effects. During bring-up software usually writes the same pattern (for example 0x0001A3EF) to both registers. That clears any old flags and enables the same events.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word, the enable word and `irq_out` are all zero.
- R2: A one on bit i of `evt_pulse` at a clock edge sets status bit i. The bit stays set until it is cleared by software.
- R3: A write with `csr_sel` = 0 clears exactly the status bits whose `csr_wdata` bit is one. Status bits written as zero keep their value.
- R4: If an event pulse and a software clear hit the same status bit on the same edge, the bit ends up set.
- R5: A write with `csr_sel` = 1 loads `csr_wdata` into the enable word. An enable word of zero keeps `irq_out` low.
- R6: `irq_out` at edge k+1 equals the OR of (status AND enable) after edge k.
- R7: `pend_tx` is high when (status AND enable AND 0x00000025) is non-zero.
- R8: `pend_rx` is high when (status AND enable AND 0x000000C0) is non-zero.
- R9: `pend_fatal` is high when (status AND enable AND 0x0000230A) is non-zero.
- R10: `tx_halted` equals status bit 2 and does not depend on the enable word.
- R11: `csr_rdata` returns the status word when `csr_sel` = 0 and the enable word when `csr_sel` = 1. Reads change no state.
- R12: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 32 | Event pulses, one per status bit |
| csr_sel | input | 1 | Register select: 0 status, 1 enable |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for the selected register |
| irq_out | output | 1 | Registered interrupt level |
| pend_tx | output | 1 | Enabled transmit event pending |
| pend_rx | output | 1 | Enabled receive event pending |
| pend_fatal | output | 1 | Enabled fatal event pending |
| tx_halted | output | 1 | Raw transmit-halted flag (status bit 2) |

## Verification
The assertions assume that every input is at a known value at each edge once reset is released. They also assume that `evt_pulse` values sampled during reset do not count. The checker ignores the first edge after reset for that reason. The stimulus changes inputs only on the falling edge, so nothing moves near a sampling edge. The stimulus sweeps every bit position for setting, clearing, enabling and group summaries. It also drives event pulses during clears, with the same bits and with different bits.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned IRQ_W = 32;
  localparam int unsigned N_GRP = 3;
  // group order: 0 transmit, 1 receive, 2 fatal
  localparam logic [IRQ_W-1:0] GRP_MASK [N_GRP] = '{
    32'h0000_0025, 32'h0000_00C0, 32'h0000_230A
  };
  localparam int unsigned TX_HALT_BIT = 2;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} csr_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  logic [W-1:0] kill;

  always_comb kill = clr_en ? clr_vec : '0;

  // set has priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~kill) | set_vec;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] enable
);
  always_ff @(posedge clk) begin
    if (!rst_n)  enable <= '0;
    else if (ld) enable <= ld_val;
  end
endmodule

// File: rtl/irq_group_summary.sv
module irq_group_summary
  import irq_pkg::*;
#(
  parameter int unsigned W = IRQ_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] enable,
  output logic [N_GRP-1:0] grp_pend,
  output logic         irq_q
);
  logic [W-1:0] live;

  always_comb live = status & enable;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign grp_pend[g] = |(live & GRP_MASK[g][W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt_pulse,
  input  logic             csr_sel,
  input  logic             csr_wr,
  input  logic [IRQ_W-1:0] csr_wdata,
  output logic [IRQ_W-1:0] csr_rdata,
  output logic             irq_out,
  output logic             pend_tx,
  output logic             pend_rx,
  output logic             pend_fatal,
  output logic             tx_halted
);
  logic [IRQ_W-1:0] status_q;
  logic [IRQ_W-1:0] enable_q;
  logic [N_GRP-1:0] grp_pend;
  logic             wr_status;
  logic             wr_enable;

  always_comb begin
    wr_status = csr_wr && (csr_sel_e'(csr_sel) == SEL_STATUS);
    wr_enable = csr_wr && (csr_sel_e'(csr_sel) == SEL_ENABLE);
  end

  irq_status_bank #(.W(IRQ_W)) u_status (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_pulse),
    .clr_en(wr_status), .clr_vec(csr_wdata), .status(status_q)
  );

  irq_enable_reg #(.W(IRQ_W)) u_enable (
    .clk(clk), .rst_n(rst_n), .ld(wr_enable),
    .ld_val(csr_wdata), .enable(enable_q)
  );

  irq_group_summary #(.W(IRQ_W)) u_summary (
    .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q),
    .grp_pend(grp_pend), .irq_q(irq_out)
  );

  always_comb begin
    csr_rdata  = (csr_sel_e'(csr_sel) == SEL_ENABLE) ? enable_q : status_q;
    pend_tx    = grp_pend[0];
    pend_rx    = grp_pend[1];
    pend_fatal = grp_pend[2];
    tx_halted  = status_q[TX_HALT_BIT];
  end
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] evt_pulse,
  input logic        csr_sel,
  input logic        csr_wr,
  input logic [31:0] csr_wdata,
  input logic [31:0] status_q,
  input logic [31:0] enable_q,
  input logic        irq_out,
  input logic        pend_tx
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (status_q == '0 && enable_q == '0 && !irq_out));

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !(csr_wr && !csr_sel)) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && csr_wr && !csr_sel && evt_pulse == '0)
      |=> (status_q == ($past(status_q) & ~$past(csr_wdata))));

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && csr_wr && !csr_sel) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));

  assert_enable_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && csr_wr && csr_sel) |=> (enable_q == $past(csr_wdata)));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && enable_q == '0) |=> !irq_out);

  assert_irq_lag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(irq_out)) |-> ($past(status_q & enable_q) != '0));

  assert_tx_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_tx |-> ((status_q & 32'h25) != '0));

  assert_other_reg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && csr_wr && !csr_sel) |=> $stable(enable_q));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .csr_sel(csr_sel),
  .csr_wr(csr_wr), .csr_wdata(csr_wdata), .status_q(status_q),
  .enable_q(enable_q), .irq_out(irq_out), .pend_tx(pend_tx)
);

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt_pulse;
  logic        csr_sel;
  logic        csr_wr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        irq_out, pend_tx, pend_rx, pend_fatal, tx_halted;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_st, m_en;
  logic        m_irq;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .csr_sel(csr_sel),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_out(irq_out), .pend_tx(pend_tx), .pend_rx(pend_rx),
    .pend_fatal(pend_fatal), .tx_halted(tx_halted)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: inputs applied at negedge, model updated, outputs checked at next negedge
  task automatic step(input logic [31:0] ev, input logic wr, input logic sel,
                      input logic [31:0] wd);
    evt_pulse = ev; csr_wr = wr; csr_sel = sel; csr_wdata = wd;
    @(posedge clk);
    m_irq = |(m_st & m_en);
    if (wr && !sel) m_st = m_st & ~wd;
    if (wr && sel)  m_en = wd;
    m_st = m_st | ev;
    @(negedge clk);
    evt_pulse = '0; csr_wr = 1'b0;
  endtask

  task automatic check_all(input string tag);
    csr_sel = 1'b0; #1;
    chk({tag, " R11 status read"}, csr_rdata, m_st);
    csr_sel = 1'b1; #1;
    chk({tag, " R11 enable read"}, csr_rdata, m_en);
    chk({tag, " R6 irq"}, {31'd0, irq_out}, {31'd0, m_irq});
    chk({tag, " R7 tx group"}, {31'd0, pend_tx}, {31'd0, |(m_st & m_en & 32'h25)});
    chk({tag, " R8 rx group"}, {31'd0, pend_rx}, {31'd0, |(m_st & m_en & 32'hC0)});
    chk({tag, " R9 fatal group"}, {31'd0, pend_fatal}, {31'd0, |(m_st & m_en & 32'h230A)});
    chk({tag, " R10 halted"}, {31'd0, tx_halted}, {31'd0, m_st[2]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; evt_pulse = 32'hFFFF_FFFF; csr_sel = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
    m_st = '0; m_en = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    evt_pulse = '0;
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // per-bit sweep: set (R2), enable (R5/R6), partial clear (R3), full clear
    for (int i = 0; i < 32; i++) begin
      step(32'd1 << i, 1'b0, 1'b0, '0);
      check_all("R2 set");
      step('0, 1'b0, 1'b0, '0);
      check_all("R2 sticky");
      step('0, 1'b1, 1'b1, 32'd1 << i);
      check_all("R5 enable");
      step('0, 1'b0, 1'b0, '0);
      check_all("R6 lag");
      step('0, 1'b1, 1'b0, ~(32'd1 << i));
      check_all("R3 zero keeps");
      step('0, 1'b1, 1'b0, 32'd1 << i);
      check_all("R3 clear");
      step('0, 1'b0, 1'b0, '0);
      check_all("R6 drop");
    end

    // bring-up pattern written to both registers (R12)
    step(32'hFFFF_FFFF, 1'b0, 1'b0, '0);
    step('0, 1'b1, 1'b1, 32'h0001_A3EF);
    check_all("R12 enable write keeps status");
    step('0, 1'b1, 1'b0, 32'h0001_A3EF);
    check_all("R12 status write keeps enable");

    // collision: event and clear on same bits (R4) and different bits
    for (int i = 0; i < 32; i++) begin
      step(32'd1 << i, 1'b1, 1'b0, 32'hFFFF_FFFF);
      check_all("R4 set wins");
      step(32'd1 << ((i + 7) % 32), 1'b1, 1'b0, 32'd1 << i);
      check_all("R4 other bit");
    end

    // mask zero keeps irq low (R5)
    step(32'hFFFF_FFFF, 1'b1, 1'b1, '0);
    step('0, 1'b0, 1'b0, '0);
    check_all("R5 masked");

    // pseudo-random mixed traffic
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ev, wd;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ev = lfsr & {lfsr[15:0], lfsr[31:16]};
      wd = lfsr ^ 32'h5A5A_A5A5;
      step(ev, lfsr[3], lfsr[7], wd);
      check_all("R6 mixed");
    end

    // repeated reads change nothing (R11)
    for (int n = 0; n < 4; n++) begin
      step('0, 1'b0, n[0], '0);
      check_all("R11 read only");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule